// File: doc/BRIEF.md
# GPIO Pin Interrupt Register Bank

This block watches a bank of general-purpose input pins and turns their activity into interrupts. Each pin can raise four kinds of event: input held low, input held high, a falling transition and a rising transition. Pins are first passed through a two-stage synchroniser. The block then keeps three views of the events as memory-mapped register arrays. The raw view shows every event whether or not it is enabled. The enable view selects which events may interrupt. The masked view is the raw view gated by the enables. One registered output combines every masked bit into a single interrupt line.

Software reaches the arrays over a plain 32-bit register bus with a transfer-size input. The bus does not honour partial-word writes. A byte or halfword write is spread across every lane of the target word before it lands. Software must therefore update whole words, and the bench checks that the spreading really happens.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset all enable bits and all sticky edge bits are zero, the interrupt output is low, and every raw field of a low pin reads 0x1.
- R2: Each pin owns a 4-bit field with these bits: bit 0 low level, bit 1 high level, bit 2 falling edge, bit 3 rising edge. Pin n lives in word n/8 of each array, at bit 4*(n%8). The arrays sit at these byte addresses: enable 0x00–0x0F, masked 0x10–0x1F, raw 0x20–0x2F. A word write to the enable array (size code 2) stores the full word.
- R3: A byte write (size code 0) takes the byte from the data lane selected by address bits [1:0] and writes it into all four lanes of the addressed word.
- R4: A halfword write (size code 1) takes the half selected by address bit 1 and writes it into both halves of the word.
- R5: Field bits belonging to pin positions beyond the last pin are not stored and read as zero.
- R6: Writes to the masked array have no effect on any state.
- R7: The raw level bits follow the synchronised pin level, and writing to them has no effect.
- R8: Raw edge bits are sticky. A bit is set when its direction of change is seen on the synchronised input, and it stays set after the pin changes again.
- R9: Writing 1 to a raw edge bit clears it. Writing 0 leaves it unchanged.
- R10: Each masked bit equals its raw bit AND its enable bit.
- R11: When an edge is detected in the same cycle as a write-1-to-clear of that bit, the bit ends up set.
- R12: Reads from byte addresses 0x30–0x3F return zero.
- R13: The interrupt output is the registered OR of all masked bits. It rises one cycle after the enable write that unmasks a pending bit takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | NUM_PINS | Asynchronous pin inputs |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | ADDR_W | Byte address within the block |
| bus_size_i | input | 2 | Transfer size: 0 byte, 1 halfword, 2 word |
| bus_wdata_i | input | 32 | Write data, in the natural byte lanes |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench uses narrow writes to different lanes and checks that the whole word takes the replicated value. A design that merged bytes would leave the other lanes at their old contents. A halfword write into the last, partly populated word checks that missing pins stay at zero. A clear is timed to land in the very cycle an edge is detected; if the clear won, the event would vanish. Further checks confirm that edge bits survive the opposite transition, that writes to level bits and to the masked array leave the readback unchanged, and that the interrupt rises exactly one cycle after unmasking, not at the same moment.

// File: rtl/gpio_irq_pkg.sv
// Shared constants and the write-widening function for the GPIO interrupt bank.
// Assumes 32-bit words, 4-bit fields, eight fields per word.
package gpio_irq_pkg;

    localparam int WORD_W        = 32;
    localparam int FIELD_W       = 4;
    localparam int PINS_PER_WORD = WORD_W / FIELD_W;

    // Field bit positions (decoded by software, so fixed)
    localparam int FB_LOW  = 0;
    localparam int FB_HIGH = 1;
    localparam int FB_FALL = 2;
    localparam int FB_RISE = 3;

    // Array select codes taken from the top two address bits
    localparam logic [1:0] ARR_ENABLE = 2'd0;
    localparam logic [1:0] ARR_MASKED = 2'd1;
    localparam logic [1:0] ARR_RAW    = 2'd2;

    // Transfer size codes
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    // Spread a narrow write over every lane of the word
    function automatic logic [WORD_W-1:0] widen_write(
        input logic [WORD_W-1:0] data,
        input logic [1:0]        lane,
        input logic [1:0]        size
    );
        logic [7:0]  b;
        logic [15:0] h;
        b = data[{lane, 3'b000} +: 8];
        h = lane[1] ? data[31:16] : data[15:0];
        case (size)
            SZ_BYTE: return {4{b}};
            SZ_HALF: return {2{h}};
            default: return data;
        endcase
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
// Two-flop synchroniser plus one history flop per pin, producing the
// synchronised level and single-cycle rise/fall pulses.
// Assumes pins are quasi-static relative to clk; resets all stages to 0.
module gpio_pin_sync #(
    parameter int NUM_PINS = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    output logic [NUM_PINS-1:0] level_o,
    output logic [NUM_PINS-1:0] rise_o,
    output logic [NUM_PINS-1:0] fall_o
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic meta_q, sync_q, hist_q;

        // Capture the pin, resolve metastability, keep one cycle of history
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                hist_q <= 1'b0;
            end else begin
                meta_q <= pins_i[p];
                sync_q <= meta_q;
                hist_q <= sync_q;
            end
        end

        assign level_o[p] = sync_q;
        assign rise_o[p]  = sync_q & ~hist_q;
        assign fall_o[p]  = ~sync_q & hist_q;
    end

endmodule

// File: rtl/gpio_bus_decode.sv
// Decodes the register bus: array select, word index, widened write data
// and per-array write strobes. Writes aimed at the masked array are dropped.
// Assumes the address layout {array[1:0], word[WORDS_LOG-1:0], lane[1:0]}.
module gpio_bus_decode
    import gpio_irq_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int WORDS_LOG = 2
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic [31:0]       wdata_i,
    output logic [1:0]        arr_o,
    output logic [WORDS_LOG-1:0] idx_o,
    output logic [31:0]       wide_o,
    output logic              en_we_o,
    output logic              raw_we_o
);

    // Split the address and widen the write data
    always_comb begin
        arr_o    = addr_i[ADDR_W-1 -: 2];
        idx_o    = addr_i[WORDS_LOG+1:2];
        wide_o   = widen_write(wdata_i, addr_i[1:0], size_i);
        en_we_o  = wr_i && (arr_o == ARR_ENABLE);
        raw_we_o = wr_i && (arr_o == ARR_RAW);
    end

endmodule

// File: rtl/gpio_irq_regs.sv
// Per-pin enable and sticky edge storage, raw/masked views, read mux and
// the registered combined interrupt.
// Assumes write strobes are already decoded; edge set dominates clear.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS  = 31,
    parameter int NUM_WORDS = 4,
    parameter int WORDS_LOG = 2,
    localparam int FLAT_W   = NUM_WORDS * WORD_W,
    localparam int USED_W   = NUM_PINS * FIELD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PINS-1:0]  level_i,
    input  logic [NUM_PINS-1:0]  rise_i,
    input  logic [NUM_PINS-1:0]  fall_i,
    input  logic                 en_we_i,
    input  logic                 raw_we_i,
    input  logic [WORDS_LOG-1:0] idx_i,
    input  logic [31:0]          wide_i,
    input  logic [1:0]           rd_arr_i,
    output logic [31:0]          rdata_o,
    output logic                 irq_o,
    output logic [FLAT_W-1:0]    en_flat_o,
    output logic [FLAT_W-1:0]    masked_flat_o,
    output logic [FLAT_W-1:0]    set_flat_o,
    output logic [FLAT_W-1:0]    edge_flat_o
);

    logic [USED_W-1:0] en_v, raw_v, set_v, edge_v;
    logic [FLAT_W-1:0] raw_flat;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_field
        localparam int WI  = p / PINS_PER_WORD;
        localparam int OFF = (p % PINS_PER_WORD) * FIELD_W;
        localparam int B   = p * FIELD_W;

        logic         hit;
        logic [3:0]   en_q;
        logic         rise_q, fall_q;
        logic         clr_rise, clr_fall;

        assign hit      = (idx_i == WORDS_LOG'(WI));
        assign clr_rise = raw_we_i && hit && wide_i[OFF+FB_RISE];
        assign clr_fall = raw_we_i && hit && wide_i[OFF+FB_FALL];

        // Enable field: loaded from the widened word when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)              en_q <= '0;
            else if (en_we_i && hit) en_q <= wide_i[OFF +: FIELD_W];
        end

        // Sticky edge bits: a new edge outranks a clear in the same cycle
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rise_q <= 1'b0;
                fall_q <= 1'b0;
            end else begin
                rise_q <= (rise_q & ~clr_rise) | rise_i[p];
                fall_q <= (fall_q & ~clr_fall) | fall_i[p];
            end
        end

        assign en_v[B +: FIELD_W]   = en_q;
        assign raw_v[B +: FIELD_W]  = {rise_q, fall_q, level_i[p], ~level_i[p]};
        assign set_v[B +: FIELD_W]  = {rise_i[p], fall_i[p], 2'b00};
        assign edge_v[B +: FIELD_W] = {rise_q, fall_q, 2'b00};
    end

    assign en_flat_o     = FLAT_W'(en_v);
    assign raw_flat      = FLAT_W'(raw_v);
    assign set_flat_o    = FLAT_W'(set_v);
    assign edge_flat_o   = FLAT_W'(edge_v);
    assign masked_flat_o = en_flat_o & raw_flat;

    // Combined interrupt, registered
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |masked_flat_o;
    end

    // Read mux over the three arrays; anything else reads zero
    always_comb begin
        rdata_o = '0;
        if (32'(idx_i) < NUM_WORDS) begin
            case (rd_arr_i)
                ARR_ENABLE: rdata_o = en_flat_o[{idx_i, 5'b00000} +: WORD_W];
                ARR_MASKED: rdata_o = masked_flat_o[{idx_i, 5'b00000} +: WORD_W];
                ARR_RAW:    rdata_o = raw_flat[{idx_i, 5'b00000} +: WORD_W];
                default:    rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_bank.sv
// Top of the GPIO interrupt register bank: synchroniser, bus decode and
// register storage. Assumes a single-cycle write strobe and a combinational read.
module gpio_irq_bank #(
    parameter int  NUM_PINS  = 31,
    localparam int NUM_WORDS = (NUM_PINS + 7) / 8,
    localparam int WORDS_LOG = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int ADDR_W    = WORDS_LOG + 4,
    localparam int FLAT_W    = NUM_WORDS * 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic                bus_wr_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [1:0]          bus_size_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    output logic                irq_o
);

    logic [NUM_PINS-1:0]  level, rise, fall;
    logic [1:0]           arr;
    logic [WORDS_LOG-1:0] idx;
    logic [31:0]          wide;
    logic                 en_we, raw_we;
    logic [FLAT_W-1:0]    en_flat, masked_flat, set_flat, edge_flat;

    gpio_pin_sync #(.NUM_PINS(NUM_PINS)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_i  (pins_i),
        .level_o (level),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    gpio_bus_decode #(.ADDR_W(ADDR_W), .WORDS_LOG(WORDS_LOG)) dec_i (
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .size_i   (bus_size_i),
        .wdata_i  (bus_wdata_i),
        .arr_o    (arr),
        .idx_o    (idx),
        .wide_o   (wide),
        .en_we_o  (en_we),
        .raw_we_o (raw_we)
    );

    gpio_irq_regs #(
        .NUM_PINS  (NUM_PINS),
        .NUM_WORDS (NUM_WORDS),
        .WORDS_LOG (WORDS_LOG)
    ) regs_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .level_i       (level),
        .rise_i        (rise),
        .fall_i        (fall),
        .en_we_i       (en_we),
        .raw_we_i      (raw_we),
        .idx_i         (idx),
        .wide_i        (wide),
        .rd_arr_i      (arr),
        .rdata_o       (bus_rdata_o),
        .irq_o         (irq_o),
        .en_flat_o     (en_flat),
        .masked_flat_o (masked_flat),
        .set_flat_o    (set_flat),
        .edge_flat_o   (edge_flat)
    );

endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Property checker for gpio_irq_bank, attached by bind below.
module gpio_irq_bank_chk #(
    parameter int ADDR_W = 6,
    parameter int FLAT_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [31:0]       bus_rdata_o,
    input logic              irq_o,
    input logic [FLAT_W-1:0] en_flat,
    input logic [FLAT_W-1:0] masked_flat,
    input logic [FLAT_W-1:0] set_flat,
    input logic [FLAT_W-1:0] edge_flat
);

    p_irq_registered_r13: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|masked_flat));

    p_masked_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i[ADDR_W-1 -: 2] == 2'd1) |=> $stable(en_flat));

    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i[ADDR_W-1 -: 2] == 2'd3) |-> (bus_rdata_o == 32'd0));

    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_flat & $past(set_flat)) == $past(set_flat));

    p_edge_needs_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_flat & ~$past(edge_flat) & ~$past(set_flat)) == '0);

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.ADDR_W(ADDR_W), .FLAT_W(FLAT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .en_flat     (en_flat),
    .masked_flat (masked_flat),
    .set_flat    (set_flat),
    .edge_flat   (edge_flat)
);

// File: tb/gpio_irq_bank_tb_top.sv
// Scoreboard bench: driver tasks queue expected values, a monitor at the
// falling edge pops and compares them against the outputs.
module gpio_irq_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [30:0] pins;
    logic        wr;
    logic [5:0]  addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    item_t cur;
    logic [31:0] act;

    always #2.5 clk = ~clk;

    gpio_irq_bank dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pins_i      (pins),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_size_i  (size),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    // Monitor: compare one queued expectation per falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            act = cur.is_irq ? {31'b0, irq} : rdata;
            checks++;
            if (act !== cur.exp) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h", cur.tag, act, cur.exp);
            end
        end
    end

    task automatic bus_write(input logic [5:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(posedge clk); #1;
        wr = 1'b1; addr = a; size = sz; wdata = d;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        addr = a;
        exp_q.push_back('{1'b0, e, tag});
        @(posedge clk); #1;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        exp_q.push_back('{1'b1, {31'b0, e}, tag});
        @(posedge clk); #1;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n = 1'b0; pins = '0; wr = 1'b0; addr = '0; size = 2'd2; wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_rd(6'h00, 32'h0000_0000, "R1 enable w0");
        expect_rd(6'h0C, 32'h0000_0000, "R1 enable w3");
        expect_rd(6'h20, 32'h1111_1111, "R1 raw w0");
        expect_rd(6'h2C, 32'h0111_1111, "R1 raw w3 (R5 top field)");
        expect_rd(6'h10, 32'h0000_0000, "R1 masked w0");
        expect_irq(1'b0, "R1 irq");
        // R12 unmapped
        expect_rd(6'h30, 32'h0000_0000, "R12 unmapped 0x30");
        expect_rd(6'h3D, 32'h0000_0000, "R12 unmapped 0x3D");

        // R2 word write
        bus_write(6'h04, 2'd2, 32'hA5A5_5A5A);
        expect_rd(6'h04, 32'hA5A5_5A5A, "R2 word write en w1");
        // R5 missing pin positions
        bus_write(6'h0C, 2'd2, 32'hFFFF_FFFF);
        expect_rd(6'h0C, 32'h0FFF_FFFF, "R5 word write en w3");

        // R3 byte writes replicate
        bus_write(6'h01, 2'd0, 32'h0000_0100);
        expect_rd(6'h00, 32'h0101_0101, "R3 byte lane1");
        bus_write(6'h03, 2'd0, 32'hC300_0000);
        expect_rd(6'h00, 32'hC3C3_C3C3, "R3 byte lane3");
        // R4 halfword writes replicate
        bus_write(6'h02, 2'd1, 32'h1234_0000);
        expect_rd(6'h00, 32'h1234_1234, "R4 half upper");
        bus_write(6'h0C, 2'd1, 32'h0000_BEEF);
        expect_rd(6'h0C, 32'h0EEF_BEEF, "R4 half lower into w3 (R5)");

        // clear all enables
        for (int w = 0; w < 4; w++) bus_write(6'(w * 4), 2'd2, 32'h0);
        expect_rd(6'h04, 32'h0000_0000, "R2 enable cleared");

        // R6 masked array is read-only
        bus_write(6'h10, 2'd2, 32'hFFFF_FFFF);
        expect_rd(6'h10, 32'h0000_0000, "R6 masked after write");
        expect_rd(6'h00, 32'h0000_0000, "R6 enable untouched");
        expect_rd(6'h20, 32'h1111_1111, "R6 raw untouched");

        // R8 rising edge on pin 9
        pins[9] = 1'b1;
        settle(5);
        expect_rd(6'h24, 32'h1111_11A1, "R8 rise pin9");
        // R7 level bits ignore writes
        bus_write(6'h24, 2'd2, 32'h0000_0033);
        expect_rd(6'h24, 32'h1111_11A1, "R7 level write ignored");
        pins[9] = 1'b0;
        settle(5);
        expect_rd(6'h24, 32'h1111_11D1, "R8 rise sticky after fall");

        // R9 write-1-to-clear
        bus_write(6'h24, 2'd2, 32'h0000_0000);
        expect_rd(6'h24, 32'h1111_11D1, "R9 zero write keeps");
        bus_write(6'h24, 2'd2, 32'h0000_0080);
        expect_rd(6'h24, 32'h1111_1151, "R9 clear rise");
        bus_write(6'h24, 2'd2, 32'h0000_0040);
        expect_rd(6'h24, 32'h1111_1111, "R9 clear fall");

        // R10 / R13 masking and registered interrupt
        pins[0] = 1'b1;
        settle(5);
        expect_rd(6'h20, 32'h1111_111A, "R8 rise pin0");
        expect_irq(1'b0, "R13 irq before enable");
        bus_write(6'h00, 2'd2, 32'h0000_0008);
        expect_irq(1'b0, "R13 irq not same cycle");
        expect_irq(1'b1, "R13 irq one cycle later");
        expect_rd(6'h10, 32'h0000_0008, "R10 masked rise pin0");
        bus_write(6'h00, 2'd2, 32'h0000_0004);
        expect_rd(6'h10, 32'h0000_0000, "R10 masked with fall enable only");
        bus_write(6'h00, 2'd2, 32'h0000_0000);
        settle(2);
        expect_irq(1'b0, "R13 irq after disable");

        // R11 set wins over simultaneous clear
        bus_write(6'h20, 2'd2, 32'h0000_000C);
        expect_rd(6'h20, 32'h1111_1112, "R9 clear both pin0");
        pins[0] = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        wr = 1'b1; addr = 6'h20; size = 2'd2; wdata = 32'h0000_0004;
        @(posedge clk); #1;
        wr = 1'b0;
        settle(1);
        expect_rd(6'h20, 32'h1111_1115, "R11 fall kept over clear");

        settle(2);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule